// File: doc/BRIEF.md
# Debug Trigger Chain Combiner

This block turns the raw match results of ten hardware debug triggers into final fire decisions. The triggers sit in five fixed pairs: pair g holds triggers 2g and 2g+1. The pairs watch, in order, fetch/fetch, store/store, load/load, fetch/store and fetch/load events. Each trigger has an enable and a timing bit. Timing 0 asks for the trap at the current instruction and timing 1 asks for it at the next instruction. Each pair has a link bit that ties its two triggers together, so that they fire only as a unit.

The comparators upstream supply a hit vector each cycle. The block applies the enable, link and timing rules to that vector without any register delay. It drives a per-trigger fire vector and two summary flags, one for "trap now" and one for "trap on next instruction". A small write port loads the per-trigger settings. This port has no back-pressure: a write is accepted in every cycle in which it is valid.

Top module: `trig_chain_combiner`

## Requirements
- R1: After reset every enable, timing bit and link bit is 0. No fire output is high, whatever the hit inputs are.
- R2: A write with `cfg_wr_valid` high updates the enable and timing of trigger `cfg_wr_idx` at the next rising clock edge. Before that edge the fire outputs still follow the old settings. A write whose index is 10 or more changes nothing.
- R3: An enabled trigger in an unlinked pair fires in the same cycle as its own hit, independently of its partner.
- R4: A disabled trigger never fires, whether its pair is linked or not. In a linked pair, a disabled partner also keeps the enabled trigger from firing.
- R5: In a linked pair whose timings agree, both triggers fire together exactly when both are enabled and both hit. With hits 00, 01 or 10 neither trigger fires.
- R6: In a linked pair whose two timing bits differ, neither trigger fires, even when both hit.
- R7: Pair 1 (triggers 2 and 3, the store/store pair) cannot be linked. A link request written to it is ignored, and each of its triggers keeps firing on its own hit.
- R8: A pair's link bit is written only by a write to the pair's even index 2g (field `cfg_wr_link`). A write to the odd index 2g+1 leaves the link bit unchanged.
- R9: `fire_now` is high when a firing trigger has timing 0. `fire_next` is high when a firing trigger has timing 1. Both are low when nothing fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | Settings write strobe |
| cfg_wr_idx | input | 4 | Trigger index of the write |
| cfg_wr_enable | input | 1 | Enable value to store |
| cfg_wr_timing | input | 1 | Timing value to store (0 = now, 1 = next instruction) |
| cfg_wr_link | input | 1 | Link value for the pair (taken only at even index) |
| hit_i | input | 10 | Raw per-trigger match results |
| fire_o | output | 10 | Final per-trigger fire decisions |
| fire_now | output | 1 | Some trigger with timing 0 fires |
| fire_next | output | 1 | Some trigger with timing 1 fires |

## Verification
The bench walks a linked pair through all four hit combinations. A design that ORs the hits instead of ANDing them would fire on a single hit. It then tries both orders of disagreeing timing bits. A design that only compared the timings one way, or picked one trigger's timing, would fire in one of those cases. The bench also tries to link the store/store pair, writes the link field through an odd index, and writes an out-of-range index. A faulty design would then tie triggers 2 and 3 together, link the wrong pair, or corrupt a stored setting. Every write also checks that the outputs still follow the old settings until the clock edge.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NUM_TRIG = 10;
  localparam int NUM_PAIR = NUM_TRIG / 2;
  localparam int IDX_W    = $clog2(NUM_TRIG + 1);
  // pair 1 (store/store) may not be linked
  localparam logic [NUM_PAIR-1:0] LINK_ALLOW = 5'b11101;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs #(
  parameter int N  = trig_pkg::NUM_TRIG,
  parameter int G  = N / 2,
  parameter int IW = $clog2(N + 1),
  parameter logic [G-1:0] LINK_ALLOW = trig_pkg::LINK_ALLOW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_enable,
  input  logic          wr_timing,
  input  logic          wr_link,
  output logic [N-1:0]  en_q,
  output logic [N-1:0]  tim_q,
  output logic [G-1:0]  link_q
);
  for (genvar i = 0; i < N; i++) begin : g_trig
    logic sel, en_r, tim_r;
    assign sel = wr_valid && (wr_idx == IW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r  <= 1'b0;
        tim_r <= 1'b0;
      end else if (sel) begin
        en_r  <= wr_enable;
        tim_r <= wr_timing;
      end
    end
    assign en_q[i]  = en_r;
    assign tim_q[i] = tim_r;

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_idx == IW'(i)) |=> (en_q[i] == $past(wr_enable) && tim_q[i] == $past(wr_timing)));
  end

  for (genvar g = 0; g < G; g++) begin : g_pair
    if (LINK_ALLOW[g]) begin : g_link
      logic sel, link_r;
      assign sel = wr_valid && (wr_idx == IW'(2 * g));
      always_ff @(posedge clk) begin
        if (!rst_n)   link_r <= 1'b0;
        else if (sel) link_r <= wr_link;
      end
      assign link_q[g] = link_r;

      assert_odd_keeps_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_idx == IW'(2 * g + 1)) |=> $stable(link_q[g]));
    end else begin : g_nolink
      assign link_q[g] = 1'b0;
    end
  end

  assert_oor_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_idx >= IW'(N)) |=> ($stable(en_q) && $stable(tim_q) && $stable(link_q)));
endmodule

// File: rtl/trig_pair_eval.sv
module trig_pair_eval (
  input  logic [1:0] hit,
  input  logic [1:0] en,
  input  logic [1:0] tim,
  input  logic       link,
  output logic [1:0] fire
);
  logic [1:0] qual;
  logic       both, same_tim;
  always_comb begin
    qual     = hit & en;
    both     = &qual;
    same_tim = (tim[0] == tim[1]);
    fire     = link ? {2{both & same_tim}} : qual;
  end
endmodule

// File: rtl/trig_fire_reduce.sv
module trig_fire_reduce #(
  parameter int N = trig_pkg::NUM_TRIG
) (
  input  logic [N-1:0] fire,
  input  logic [N-1:0] tim,
  output logic         now,
  output logic         next
);
  always_comb begin
    now  = |(fire & ~tim);
    next = |(fire & tim);
  end
endmodule

// File: rtl/trig_chain_combiner.sv
module trig_chain_combiner #(
  parameter int N  = trig_pkg::NUM_TRIG,
  parameter int G  = N / 2,
  parameter int IW = $clog2(N + 1),
  parameter logic [G-1:0] LINK_ALLOW = trig_pkg::LINK_ALLOW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_valid,
  input  logic [IW-1:0] cfg_wr_idx,
  input  logic          cfg_wr_enable,
  input  logic          cfg_wr_timing,
  input  logic          cfg_wr_link,
  input  logic [N-1:0]  hit_i,
  output logic [N-1:0]  fire_o,
  output logic          fire_now,
  output logic          fire_next
);
  logic [N-1:0] en_q, tim_q;
  logic [G-1:0] link_q;

  trig_cfg_regs #(.N(N), .G(G), .IW(IW), .LINK_ALLOW(LINK_ALLOW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(cfg_wr_valid), .wr_idx(cfg_wr_idx),
    .wr_enable(cfg_wr_enable), .wr_timing(cfg_wr_timing), .wr_link(cfg_wr_link),
    .en_q(en_q), .tim_q(tim_q), .link_q(link_q)
  );

  for (genvar g = 0; g < G; g++) begin : g_eval
    trig_pair_eval u_pair (
      .hit(hit_i[2*g+1 -: 2]), .en(en_q[2*g+1 -: 2]), .tim(tim_q[2*g+1 -: 2]),
      .link(link_q[g]), .fire(fire_o[2*g+1 -: 2])
    );

    assert_pair_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
      link_q[g] |-> (fire_o[2*g] == fire_o[2*g+1]));
    assert_pair_needs_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (link_q[g] && fire_o[2*g]) |-> (hit_i[2*g] && hit_i[2*g+1]));
    assert_timing_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (link_q[g] && tim_q[2*g] != tim_q[2*g+1]) |-> (fire_o[2*g+1 -: 2] == 2'b00));
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |-> !fire_o[i]);
  end

  trig_fire_reduce #(.N(N)) u_reduce (
    .fire(fire_o), .tim(tim_q), .now(fire_now), .next(fire_next)
  );

  assert_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fire_o) == (fire_now || fire_next)));
endmodule

// File: tb/test_trig_chain_combiner.sv
module test_trig_chain_combiner;
  localparam int N = 10;
  typedef struct {
    logic [N-1:0] fire;
    logic now, next;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic cfg_wr_valid = 0, cfg_wr_enable = 0, cfg_wr_timing = 0, cfg_wr_link = 0;
  logic [3:0] cfg_wr_idx = 0;
  logic [N-1:0] hit_i = 0, fire_o;
  logic fire_now, fire_next;

  trig_chain_combiner i_trig_chain_combiner (
    .clk(clk), .rst_n(rst_n), .cfg_wr_valid(cfg_wr_valid), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_enable(cfg_wr_enable), .cfg_wr_timing(cfg_wr_timing), .cfg_wr_link(cfg_wr_link),
    .hit_i(hit_i), .fire_o(fire_o), .fire_now(fire_now), .fire_next(fire_next)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t q[$];
  bit en_m[N], tim_m[N], link_m[N/2];

  function automatic exp_t model(input logic [N-1:0] h, input string tag);
    exp_t e;
    e.fire = '0; e.now = 0; e.next = 0; e.tag = tag;
    for (int g = 0; g < N/2; g++) begin
      bit a, b;
      a = h[2*g] && en_m[2*g];
      b = h[2*g+1] && en_m[2*g+1];
      if (link_m[g]) begin
        a = a && b && (tim_m[2*g] == tim_m[2*g+1]);
        b = a;
      end
      e.fire[2*g] = a; e.fire[2*g+1] = b;
    end
    for (int i = 0; i < N; i++)
      if (e.fire[i]) begin
        if (tim_m[i]) e.next = 1; else e.now = 1;
      end
    return e;
  endfunction

  // monitor: compare one expectation per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (fire_o !== e.fire || fire_now !== e.now || fire_next !== e.next) begin
          failures++;
          $display("FAIL %s: fire=%b now=%b next=%b expected fire=%b now=%b next=%b",
                   e.tag, fire_o, fire_now, fire_next, e.fire, e.now, e.next);
        end
      end
    end
  end

  task automatic apply(input logic [N-1:0] h, input string tag);
    @(posedge clk); #1;
    hit_i = h;
    q.push_back(model(h, tag));
  endtask

  // write; the cycle of the strobe is checked against the old settings (R2)
  task automatic cfg_write(input int idx, input bit en, input bit tim, input bit lk);
    @(posedge clk); #1;
    cfg_wr_valid = 1; cfg_wr_idx = 4'(idx);
    cfg_wr_enable = en; cfg_wr_timing = tim; cfg_wr_link = lk;
    q.push_back(model(hit_i, "R2 pre-edge"));
    @(posedge clk); #1;
    cfg_wr_valid = 0;
    if (idx < N) begin
      en_m[idx] = en; tim_m[idx] = tim;
      if (idx % 2 == 0 && idx / 2 != 1) link_m[idx/2] = lk;
    end
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin en_m[i] = 0; tim_m[i] = 0; end
    for (int g = 0; g < N/2; g++) link_m[g] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state, nothing fires
    apply('1, "R1 reset all hits");
    apply(10'b0000000000, "R1 reset no hits");
    // R3: enable all unlinked, timing 0
    for (int i = 0; i < N; i++) cfg_write(i, 1, 0, 0);
    apply(10'b0000000001, "R3 single hit 0");
    apply(10'b1000000000, "R3 single hit 9");
    apply(10'b0101010101, "R3 even hits");
    // R4: disable trigger 5
    cfg_write(5, 0, 0, 0);
    apply(10'b0000100000, "R4 disabled unlinked");
    // R5: link pair 0, four hit combos
    cfg_write(0, 1, 0, 1);
    apply(10'b0000000000, "R5 linked 00");
    apply(10'b0000000001, "R5 linked 01");
    apply(10'b0000000010, "R5 linked 10");
    apply(10'b0000000011, "R5 linked 11");
    // R6: timing mismatch both orders
    cfg_write(1, 1, 1, 0);
    apply(10'b0000000011, "R6 mismatch t0=0 t1=1");
    cfg_write(0, 1, 1, 1);
    cfg_write(1, 1, 0, 0);
    apply(10'b0000000011, "R6 mismatch t0=1 t1=0");
    // R9: both timing 1 -> fire_next only
    cfg_write(1, 1, 1, 0);
    apply(10'b0000000011, "R9 linked next");
    apply(10'b0000010011, "R9 now and next");
    // R4: linked pair with disabled partner
    cfg_write(1, 0, 1, 0);
    apply(10'b0000000011, "R4 linked partner disabled");
    // R7: try to link store/store pair
    cfg_write(2, 1, 0, 1);
    apply(10'b0000000100, "R7 store pair single hit 2");
    apply(10'b0000001000, "R7 store pair single hit 3");
    // R8: link via odd index is ignored
    cfg_write(5, 1, 0, 1);
    apply(10'b0000010000, "R8 odd link ignored hit 4");
    cfg_write(4, 1, 0, 1);
    apply(10'b0000010000, "R8 even link hit 4 only");
    apply(10'b0000110000, "R8 even link both");
    // R2: out-of-range index changes nothing
    cfg_write(12, 0, 1, 0);
    cfg_write(15, 0, 1, 1);
    apply(10'b1111111111, "R2 out of range ignored");
    // R1: reset again clears all
    @(posedge clk); #1 rst_n = 0;
    for (int i = 0; i < N; i++) begin en_m[i] = 0; tim_m[i] = 0; end
    for (int g = 0; g < N/2; g++) link_m[g] = 0;
    @(posedge clk); #1 rst_n = 1;
    apply('1, "R1 after second reset");
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule